// File: doc/BRIEF.md
# Alternating Byte-Pair DMA Register Steering

This block sits between an 8-bit host bus and the register file of a 16-bit disk drive bridge. An 8-bit host DMA channel can only move bytes between memory and one fixed I/O port. A 16-bit data word, however, needs two byte accesses: one to the data register (low byte) and one to the high-byte holding register. The block closes that gap with a one-bit phase flip-flop that replaces an address bit during DMA cycles. Every acknowledged DMA access is sent to the low register or the high register according to the phase, and then the phase flips. A stream of same-port DMA bytes therefore becomes a low/high/low/high sequence.

Ordinary register-addressed programmed I/O stays available. When the host decodes the card window without a DMA acknowledge, the host address picks the register directly, and the phase is left alone. Commands that use no DMA, such as a device identify, keep working this way. The drive's DMA request reaches the host only while transfers are enabled. The acknowledge toward the drive is raised only for DMA accesses. A new request, or a reset, sets the phase back to the low byte so that pairs cannot start out of step.

All outputs are registered. An access sampled on one rising clock edge shows up on the outputs right after that edge.

Top module: `ide_dma_pair_steer`

## Requirements
- R1: After reset, every output is 0 and the phase is low: the first DMA access after reset goes to the low register (index 0).
- R2: A programmed I/O access has io_sel=1, exactly one of io_rd/io_wr high, and dma_ack=0. It produces reg_stb=1 one cycle later, with reg_idx equal to io_addr, reg_wr equal to io_wr and dev_dmack=0. It leaves the phase unchanged.
- R3: A DMA access has dma_ack=1, dma_en=1 and exactly one strobe. It produces reg_stb=1 and dev_dmack=1 one cycle later. Its register index comes from the phase only: io_addr and io_sel have no effect.
- R4: The phase flips on every DMA access. The low register (index LO_IDX, default 0) is used first and the high register (LO_IDX + 2^(ADDR_W-1), default 8) second. An odd number of DMA accesses leaves the phase high.
- R5: When the qualified request (dev_dmarq AND dma_en) rises, the phase returns to low. An access in that same cycle goes to the low register.
- R6: host_drq equals dev_dmarq AND dma_en, registered by one cycle.
- R7: No access is made when dma_ack=1 with dma_en=0, when both strobes or neither strobe are high, or when io_sel=0 with dma_ack=0. In that case reg_stb, reg_wr, dev_dmack, cs_cmd and cs_ctl are 0, reg_idx is 0 and the phase is unchanged.
- R8: During reg_stb, cs_cmd=1 when reg_idx bit ADDR_W-1 is 0 and cs_ctl=1 when it is 1. Outside reg_stb both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_sel | input | 1 | Host address decode hit on the card's register window |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_addr | input | ADDR_W | Host register address within the window |
| dma_ack | input | 1 | Host DMA acknowledge for the data port |
| dma_en | input | 1 | DMA transfer enabled |
| dev_dmarq | input | 1 | DMA request from the drive |
| reg_stb | output | 1 | Register access strobe |
| reg_wr | output | 1 | Access direction, 1 = write |
| reg_idx | output | ADDR_W | Steered register index |
| cs_cmd | output | 1 | Command block select (lower half of the window) |
| cs_ctl | output | 1 | Upper half select (high byte latch / control block) |
| host_drq | output | 1 | Qualified DMA request toward the host |
| dev_dmack | output | 1 | DMA acknowledge toward the drive |

## Verification
The bench builds the block with its defaults: a 4-bit window and the data pair at indices 0 and 8. This puts every one of the 16 programmed I/O indices within reach, and both halves of the window, so both selects get exercised. Directed runs cover the corner cases. An odd count of DMA accesses must leave the next access on index 8. A fresh request, or a reset, must pull the phase back to index 0, including a request whose rise lands on the same cycle as an access. Seeded random traffic then mixes DMA, programmed I/O, illegal strobe combinations and request pulses against a cycle model of the phase.

// File: rtl/ide_tgl_pkg.sv
package ide_tgl_pkg;
  typedef enum logic {PH_LO = 1'b0, PH_HI = 1'b1} phase_e;

  typedef struct packed {
    logic valid;
    logic wr;
    logic dma;
  } access_t;
endpackage

// File: rtl/ide_tgl_decode.sv
module ide_tgl_decode
  import ide_tgl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LO_IDX = 0,
  parameter int HI_IDX = 8
) (
  input  logic              io_sel,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              dma_ack,
  input  logic              dma_en,
  input  phase_e            eff_phase,
  output logic              dma_hit,
  output access_t           acc,
  output logic [ADDR_W-1:0] acc_idx
);
  localparam logic [ADDR_W-1:0] LoIdx = ADDR_W'(LO_IDX);
  localparam logic [ADDR_W-1:0] HiIdx = ADDR_W'(HI_IDX);

  logic one_strobe;
  logic pio_hit;

  always_comb begin
    one_strobe = io_rd ^ io_wr;
    // DMA acknowledge owns the cycle; the host address is not looked at.
    dma_hit    = one_strobe & dma_ack & dma_en;
    pio_hit    = one_strobe & io_sel & ~dma_ack;
    acc.valid  = dma_hit | pio_hit;
    acc.wr     = io_wr;
    acc.dma    = dma_hit;
    if (dma_hit) begin
      acc_idx = (eff_phase == PH_HI) ? HiIdx : LoIdx;
    end else begin
      acc_idx = io_addr;
    end
  end
endmodule

// File: rtl/ide_tgl_phase.sv
module ide_tgl_phase
  import ide_tgl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_rise,
  input  logic   dma_hit,
  output phase_e eff_phase
);
  phase_e ph_q;
  phase_e ph_d;
  logic   ph_en;

  always_comb begin
    eff_phase = req_rise ? PH_LO : ph_q;
    ph_en     = dma_hit | req_rise;
    if (dma_hit) begin
      ph_d = (eff_phase == PH_LO) ? PH_HI : PH_LO;
    end else begin
      ph_d = eff_phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_LO;
    end else if (ph_en) begin
      ph_q <= ph_d;
    end
  end
endmodule

// File: rtl/ide_tgl_hshk.sv
module ide_tgl_hshk (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_dmarq,
  input  logic dma_en,
  output logic req_rise,
  output logic host_drq
);
  logic drq_d;
  logic drq_q;

  always_comb begin
    drq_d    = dev_dmarq & dma_en;
    req_rise = drq_d & ~drq_q;
    host_drq = drq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drq_q <= 1'b0;
    end else begin
      drq_q <= drq_d;
    end
  end
endmodule

// File: rtl/ide_tgl_out.sv
module ide_tgl_out
  import ide_tgl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  access_t           acc,
  input  logic [ADDR_W-1:0] acc_idx,
  output logic              reg_stb,
  output logic              reg_wr,
  output logic [ADDR_W-1:0] reg_idx,
  output logic              cs_cmd,
  output logic              cs_ctl,
  output logic              dev_dmack
);
  localparam int TopBit = ADDR_W - 1;

  logic              stb_d, wr_d, cmd_d, ctl_d, ack_d;
  logic [ADDR_W-1:0] idx_d;

  always_comb begin
    stb_d = acc.valid;
    wr_d  = acc.valid & acc.wr;
    ack_d = acc.valid & acc.dma;
    idx_d = acc.valid ? acc_idx : '0;
    cmd_d = acc.valid & ~acc_idx[TopBit];
    ctl_d = acc.valid &  acc_idx[TopBit];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_stb   <= 1'b0;
      reg_wr    <= 1'b0;
      reg_idx   <= '0;
      cs_cmd    <= 1'b0;
      cs_ctl    <= 1'b0;
      dev_dmack <= 1'b0;
    end else begin
      reg_stb   <= stb_d;
      reg_wr    <= wr_d;
      reg_idx   <= idx_d;
      cs_cmd    <= cmd_d;
      cs_ctl    <= ctl_d;
      dev_dmack <= ack_d;
    end
  end
endmodule

// File: rtl/ide_dma_pair_steer.sv
module ide_dma_pair_steer
  import ide_tgl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LO_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              dma_ack,
  input  logic              dma_en,
  input  logic              dev_dmarq,
  output logic              reg_stb,
  output logic              reg_wr,
  output logic [ADDR_W-1:0] reg_idx,
  output logic              cs_cmd,
  output logic              cs_ctl,
  output logic              host_drq,
  output logic              dev_dmack
);
  localparam int HalfWin = 2 ** (ADDR_W - 1);
  localparam int HI_IDX  = LO_IDX + HalfWin;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic              req_rise;
  logic              dma_hit;
  phase_e            eff_phase;
  access_t           acc;
  logic [ADDR_W-1:0] acc_idx;

  ide_tgl_hshk u_hshk (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .dev_dmarq (dev_dmarq),
    .dma_en    (dma_en),
    .req_rise  (req_rise),
    .host_drq  (host_drq)
  );

  ide_tgl_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_rise  (req_rise),
    .dma_hit   (dma_hit),
    .eff_phase (eff_phase)
  );

  ide_tgl_decode #(
    .ADDR_W (ADDR_W),
    .LO_IDX (LO_IDX),
    .HI_IDX (HI_IDX)
  ) u_dec (
    .io_sel    (io_sel),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_addr   (io_addr),
    .dma_ack   (dma_ack),
    .dma_en    (dma_en),
    .eff_phase (eff_phase),
    .dma_hit   (dma_hit),
    .acc       (acc),
    .acc_idx   (acc_idx)
  );

  ide_tgl_out #(
    .ADDR_W (ADDR_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .acc       (acc),
    .acc_idx   (acc_idx),
    .reg_stb   (reg_stb),
    .reg_wr    (reg_wr),
    .reg_idx   (reg_idx),
    .cs_cmd    (cs_cmd),
    .cs_ctl    (cs_ctl),
    .dev_dmack (dev_dmack)
  );
endmodule

// File: rtl/ide_dma_pair_steer_chk.sv
module ide_dma_pair_steer_chk #(
  parameter int ADDR_W = 4,
  parameter int LO_IDX = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_sel,
  input logic              io_rd,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic              dma_ack,
  input logic              dma_en,
  input logic              dev_dmarq,
  input logic              reg_stb,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_idx,
  input logic              cs_cmd,
  input logic              cs_ctl,
  input logic              host_drq,
  input logic              dev_dmack
);
  localparam logic [ADDR_W-1:0] LoIdx = ADDR_W'(LO_IDX);
  localparam logic [ADDR_W-1:0] HiIdx = ADDR_W'(LO_IDX + 2 ** (ADDR_W - 1));

  // R3: a drive acknowledge only ever lands on the data register pair
  a_r3_dmack_on_pair: assert property (@(posedge clk) disable iff (!rst_n)
    dev_dmack |-> (reg_stb && (reg_idx == LoIdx || reg_idx == HiIdx)));

  // R4: back-to-back DMA accesses alternate unless a new request realigned
  a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    dev_dmack |=> (!dev_dmack || $rose(host_drq) || reg_idx != $past(reg_idx)));

  // R5: a DMA access in the cycle of a new request is the low byte
  a_r5_realign_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(host_drq) && dev_dmack) |-> reg_idx == LoIdx);

  // R6: the host request never appears without a qualified drive request
  a_r6_drq_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    host_drq |-> $past(dev_dmarq && dma_en));

  // R7: idle outputs stay quiet
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_stb |-> (!cs_cmd && !cs_ctl && !dev_dmack && !reg_wr));

  // R8: exactly one select during an access
  a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    reg_stb |-> ($countones({cs_cmd, cs_ctl}) == 1));

  a_r8_select_half: assert property (@(posedge clk) disable iff (!rst_n)
    reg_stb |-> (cs_ctl == reg_idx[ADDR_W-1]));
endmodule

bind ide_dma_pair_steer ide_dma_pair_steer_chk #(
  .ADDR_W (ADDR_W),
  .LO_IDX (LO_IDX)
) chk_i (.*);

// File: tb/ide_dma_pair_steer_tb_top.sv
`timescale 1ns/1ps
module ide_dma_pair_steer_tb_top;
  localparam int ADDR_W = 4;
  localparam int LO = 0;
  localparam int HI = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              io_sel, io_rd, io_wr, dma_ack, dma_en, dev_dmarq;
  logic [ADDR_W-1:0] io_addr;
  logic              reg_stb, reg_wr, cs_cmd, cs_ctl, host_drq, dev_dmack;
  logic [ADDR_W-1:0] reg_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  bit m_tog;
  bit m_drq;

  always #2.5 clk = ~clk;

  ide_dma_pair_steer #(.ADDR_W(ADDR_W), .LO_IDX(LO)) dut_i (.*);

  task automatic drive(bit sel, bit rd, bit wr, logic [ADDR_W-1:0] a,
                       bit ack, bit en, bit rq);
    io_sel = sel; io_rd = rd; io_wr = wr; io_addr = a;
    dma_ack = ack; dma_en = en; dev_dmarq = rq;
  endtask

  // One clock: expected outputs from the inputs applied now, then compare.
  task automatic step(string tag);
    bit one, dh, ph, rise, eff, v;
    logic [ADDR_W-1:0] ei;
    bit ecmd, ectl, ewr, eack, edrq;
    one  = io_rd ^ io_wr;
    dh   = one & dma_ack & dma_en;
    ph   = one & io_sel & ~dma_ack;
    rise = (dev_dmarq & dma_en) & ~m_drq;
    eff  = rise ? 1'b0 : m_tog;
    v    = dh | ph;
    ei   = !v ? '0 : (dh ? (eff ? ADDR_W'(HI) : ADDR_W'(LO)) : io_addr);
    ewr  = v & io_wr;
    eack = dh;
    ecmd = v & ~ei[ADDR_W-1];
    ectl = v & ei[ADDR_W-1];
    edrq = dev_dmarq & dma_en;
    m_tog = dh ? ~eff : eff;
    m_drq = edrq;
    @(posedge clk);
    #1;
    checks++;
    if ({reg_stb, reg_wr, reg_idx, cs_cmd, cs_ctl, host_drq, dev_dmack} !==
        {v, ewr, ei, ecmd, ectl, edrq, eack}) begin
      fails++;
      $display("FAIL %s: stb/wr/idx/cmd/ctl/drq/ack actual %0b/%0b/%0d/%0b/%0b/%0b/%0b expected %0b/%0b/%0d/%0b/%0b/%0b/%0b",
               tag, reg_stb, reg_wr, reg_idx, cs_cmd, cs_ctl, host_drq, dev_dmack,
               v, ewr, ei, ecmd, ectl, edrq, eack);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(0, 0, 0, '0, 0, 0, 0);
    m_tog = 0; m_drq = 0;
    #1;
    checks++;
    if ({reg_stb, reg_wr, reg_idx, cs_cmd, cs_ctl, host_drq, dev_dmack} !== '0) begin
      fails++;
      $display("FAIL R1: outputs in reset actual %0h expected 0",
               {reg_stb, reg_wr, reg_idx, cs_cmd, cs_ctl, host_drq, dev_dmack});
    end
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step("R1");
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_2024;
    void'($urandom(seed));
    do_reset();

    // R2: programmed I/O sweep of all indices, reads and writes
    for (int i = 0; i < 16; i++) begin
      drive(1, i[0], ~i[0], ADDR_W'(i), 0, 0, 0);
      step("R2");
    end
    // R7: illegal strobes, no select, ack without enable
    drive(1, 1, 1, 4'd3, 0, 1, 0); step("R7");
    drive(1, 0, 0, 4'd3, 0, 1, 0); step("R7");
    drive(0, 1, 0, 4'd3, 0, 1, 0); step("R7");
    drive(1, 1, 0, 4'd3, 1, 0, 0); step("R7");
    // R1: first DMA after reset is low byte, no request edge
    drive(0, 1, 0, 4'd5, 1, 1, 0); step("R1");
    // R6: request qualified by enable
    drive(0, 0, 0, 0, 0, 0, 1); step("R6");
    drive(0, 0, 0, 0, 0, 0, 1); step("R6");
    // R5: request rises -> phase low even though it was high
    drive(0, 0, 0, 0, 0, 1, 1); step("R5");
    // R3/R4: three DMA accesses with junk address: 0, 8, 0
    drive(1, 1, 0, 4'd7, 1, 1, 1); step("R3");
    drive(0, 0, 1, 4'd9, 1, 1, 1); step("R4");
    drive(1, 1, 0, 4'd2, 1, 1, 1); step("R4");
    // R2: PIO in between leaves phase untouched
    drive(1, 1, 0, 4'd1, 0, 1, 1); step("R2");
    // R4: odd count left phase high -> next is 8
    drive(0, 1, 0, 4'd0, 1, 1, 1); step("R4");
    drive(0, 1, 0, 4'd0, 1, 1, 1); step("R4");
    // R5: drop request, re-raise with access in same cycle -> 0
    drive(0, 0, 0, 0, 0, 1, 0); step("R5");
    drive(0, 1, 0, 0, 1, 1, 1); step("R5");
    drive(0, 1, 0, 0, 1, 1, 1); step("R5");
    drive(0, 1, 0, 0, 1, 1, 1); step("R4");
    // R1: reset with phase high realigns to low
    do_reset();
    drive(0, 1, 0, 0, 1, 1, 0); step("R1");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit sel, rd, wr, ack, en, rq;
      int r;
      r   = $urandom % 8;
      rd  = (r < 3) ? 1'b1 : (r == 7);
      wr  = (r >= 3 && r < 6) ? 1'b1 : (r == 7);
      sel = ($urandom % 4) != 0;
      ack = ($urandom % 2) == 1;
      en  = ($urandom % 8) != 0;
      rq  = (n % 37) < 30;
      drive(sel, rd, wr, ADDR_W'($urandom), ack, en, rq);
      step("R3/R4 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule